// File: doc/BRIEF.md
# Serial bit-rate tick divider

This block sits beside the shift logic of a UART-style serial port. It turns raw clock-source ticks into one bit strobe per serial bit period, with one strobe for the transmitter and one for the receiver. The tick source and the division ratio both follow the 2-bit serial mode. The synchronous shift mode counts machine-cycle ticks. The fixed-rate nine-bit mode also counts machine-cycle ticks. The two variable-rate modes count timer overflow pulses. A double-rate control bit halves the division ratio in every mode except the shift mode.

In the variable-rate modes, each direction has its own clock-select bit. That bit picks the timer-2 overflow pulse meant for that direction, or the shared timer-1 overflow pulse. Transmit and receive can therefore run from different timers.

Each direction keeps its own tick accumulator, which advances only while that direction is active. Reaching the divisor subtracts the divisor, keeps the remainder and issues one strobe. Dropping the direction's active input clears its accumulator, so the next frame starts from zero.

Top module: `sbaud_tick_div`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, both `tx_bit_stb` and `rx_bit_stb` are 0 and both accumulators are empty.
- R2: In mode 0 (`mode` = 2'b00), each direction counts `mach_tick` and strobes once every 12 ticks. `dbl_rate` and the timer pulses have no effect.
- R3: In mode 2 (`mode` = 2'b10), each direction counts `mach_tick`. It strobes once every 16 ticks when `dbl_rate` = 1 and once every 32 ticks when `dbl_rate` = 0. The timer pulses have no effect.
- R4: In modes 1 and 3 (`mode` = 2'b01 or 2'b11), each direction counts timer overflow pulses. It strobes once every 16 pulses when `dbl_rate` = 1 and once every 32 pulses when `dbl_rate` = 0. `mach_tick` has no effect.
- R5: In modes 1 and 3, the transmit path counts `t2_tx_ovf` when `tx_clk_t2` = 1 and `t1_ovf` when `tx_clk_t2` = 0.
- R6: In modes 1 and 3, the receive path counts `t2_rx_ovf` when `rx_clk_t2` = 1 and `t1_ovf` when `rx_clk_t2` = 0. This selection is independent of the transmit selection.
- R7: While a direction's active input (`tx_active` or `rx_active`) is 0, that direction gives no strobe and its accumulator is cleared. After it becomes active again, its first strobe comes on exactly the divisor-th counted tick.
- R8: When a count reaches the divisor, the divisor is subtracted and the remainder is kept. If the divisor shrinks below the current count, a strobe follows on the next clock even without a tick, and counting resumes from the remainder.
- R9: Each strobe is registered and is high for the clock that follows the edge at which the completing tick was sampled. Each direction gives at most one strobe per clock, and the two directions never disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Serial mode (0 shift, 1 variable 8-bit, 2 fixed 9-bit, 3 variable 9-bit) |
| dbl_rate | input | 1 | Halve the division ratio (modes 1 to 3) |
| tx_clk_t2 | input | 1 | Transmit source select: 1 = timer 2, 0 = timer 1 |
| rx_clk_t2 | input | 1 | Receive source select: 1 = timer 2, 0 = timer 1 |
| mach_tick | input | 1 | Machine-cycle tick, one clock wide |
| t1_ovf | input | 1 | Timer-1 overflow pulse |
| t2_tx_ovf | input | 1 | Timer-2 overflow pulse for transmit |
| t2_rx_ovf | input | 1 | Timer-2 overflow pulse for receive |
| tx_active | input | 1 | Transmitter is sending |
| rx_active | input | 1 | Receiver is receiving |
| tx_bit_stb | output | 1 | Transmit bit strobe |
| rx_bit_stb | output | 1 | Receive bit strobe |

## Verification
The hardest case to reach from the ports is a kept remainder that already exceeds a newly smaller divisor. The stimulus builds up 20 ticks at the divide-by-32 rate, then raises `dbl_rate` with no tick present. This must yield a strobe with no tick behind it, and the next strobe must come after 12 further ticks rather than 16.

The stimulus also pauses one direction part-way through a count, to show that the count restarts. It runs the two directions from different timers at different pulse rates. A long stretch of random mode, select and tick changes is compared every clock against a behavioural model.

// File: rtl/sbaud_pkg.sv
package sbaud_pkg;

    localparam int DIV_SYNC = 12;
    localparam int DIV_FAST = 16;
    localparam int DIV_SLOW = 32;
    localparam int ACC_W    = $clog2(DIV_SLOW) + 1;

    typedef enum logic [1:0] {
        SER_SHIFT  = 2'd0,
        SER_VAR8   = 2'd1,
        SER_FIXED9 = 2'd2,
        SER_VAR9   = 2'd3
    } ser_mode_e;

    typedef struct packed {
        logic             tick;
        logic [ACC_W-1:0] div;
    } clk_pick_t;

    function automatic logic uses_timer(ser_mode_e m);
        return (m == SER_VAR8) || (m == SER_VAR9);
    endfunction

    function automatic logic [ACC_W-1:0] pick_div(ser_mode_e m, logic dbl);
        if (m == SER_SHIFT)
            return ACC_W'(DIV_SYNC);
        else if (dbl)
            return ACC_W'(DIV_FAST);
        else
            return ACC_W'(DIV_SLOW);
    endfunction

endpackage

// File: rtl/sbaud_src_sel.sv
module sbaud_src_sel
    import sbaud_pkg::*;
(
    input  ser_mode_e mode,
    input  logic      dbl_rate,
    input  logic      use_t2,
    input  logic      mach_tick,
    input  logic      t1_ovf,
    input  logic      t2_ovf,
    output clk_pick_t pick
);
    logic timer_tick;

    always_comb begin
        timer_tick = use_t2 ? t2_ovf : t1_ovf;
        pick.tick  = uses_timer(mode) ? timer_tick : mach_tick;
        pick.div   = pick_div(mode, dbl_rate);
    end
endmodule

// File: rtl/sbaud_accum.sv
module sbaud_accum
    import sbaud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  clk_pick_t pick,
    output logic      bit_stb
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    always_comb sum = acc_q + ACC_W'(pick.tick);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            acc_q   <= '0;
            bit_stb <= 1'b0;
        end else if (sum >= pick.div) begin
            acc_q   <= sum - pick.div;
            bit_stb <= 1'b1;
        end else begin
            acc_q   <= sum;
            bit_stb <= 1'b0;
        end
    end
endmodule

// File: rtl/sbaud_tick_div.sv
module sbaud_tick_div
    import sbaud_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       dbl_rate,
    input  logic       tx_clk_t2,
    input  logic       rx_clk_t2,
    input  logic       mach_tick,
    input  logic       t1_ovf,
    input  logic       t2_tx_ovf,
    input  logic       t2_rx_ovf,
    input  logic       tx_active,
    input  logic       rx_active,
    output logic       tx_bit_stb,
    output logic       rx_bit_stb
);
    localparam int NDIR = 2;

    ser_mode_e        mode_e;
    logic [NDIR-1:0]  dir_t2sel;
    logic [NDIR-1:0]  dir_t2ovf;
    logic [NDIR-1:0]  dir_act;
    logic [NDIR-1:0]  dir_stb;
    clk_pick_t        dir_pick [NDIR];

    assign mode_e    = ser_mode_e'(mode);
    assign dir_t2sel = {rx_clk_t2, tx_clk_t2};
    assign dir_t2ovf = {t2_rx_ovf, t2_tx_ovf};
    assign dir_act   = {rx_active, tx_active};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        sbaud_src_sel u_sel (
            .mode      (mode_e),
            .dbl_rate  (dbl_rate),
            .use_t2    (dir_t2sel[d]),
            .mach_tick (mach_tick),
            .t1_ovf    (t1_ovf),
            .t2_ovf    (dir_t2ovf[d]),
            .pick      (dir_pick[d])
        );
        sbaud_accum u_acc (
            .clk     (clk),
            .rst     (rst),
            .active  (dir_act[d]),
            .pick    (dir_pick[d]),
            .bit_stb (dir_stb[d])
        );
    end

    assign tx_bit_stb = dir_stb[0];
    assign rx_bit_stb = dir_stb[1];
endmodule

// File: rtl/sbaud_chk.sv
module sbaud_chk (
    input logic clk,
    input logic rst,
    input logic tx_active,
    input logic rx_active,
    input logic tx_bit_stb,
    input logic rx_bit_stb
);
    assert_tx_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_active |=> !tx_bit_stb);

    assert_rx_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !rx_active |=> !rx_bit_stb);

    // R9: a transmit strobe is the registered result of an active clock
    assert_tx_stb_from_active_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_bit_stb) |-> $past(tx_active));

    // R9: a receive strobe is the registered result of an active clock
    assert_rx_stb_from_active_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_bit_stb) |-> $past(rx_active));
endmodule

bind sbaud_tick_div sbaud_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_active  (tx_active),
    .rx_active  (rx_active),
    .tx_bit_stb (tx_bit_stb),
    .rx_bit_stb (rx_bit_stb)
);

// File: tb/sbaud_tick_div_tb.sv
module sbaud_tick_div_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic dbl_rate = 1'b0, tx_clk_t2 = 1'b0, rx_clk_t2 = 1'b0;
    logic mach_tick = 1'b0, t1_ovf = 1'b0, t2_tx_ovf = 1'b0, t2_rx_ovf = 1'b0;
    logic tx_active = 1'b0, rx_active = 1'b0;
    logic tx_bit_stb, rx_bit_stb;

    int total = 0, bad = 0;
    int tx_cnt = 0, rx_cnt = 0;
    int m_tx_acc = 0, m_rx_acc = 0;
    bit m_tx_stb = 0, m_rx_stb = 0;
    bit done = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sbaud_tick_div u_dut (
        .clk(clk), .rst(rst), .mode(mode), .dbl_rate(dbl_rate),
        .tx_clk_t2(tx_clk_t2), .rx_clk_t2(rx_clk_t2), .mach_tick(mach_tick),
        .t1_ovf(t1_ovf), .t2_tx_ovf(t2_tx_ovf), .t2_rx_ovf(t2_rx_ovf),
        .tx_active(tx_active), .rx_active(rx_active),
        .tx_bit_stb(tx_bit_stb), .rx_bit_stb(rx_bit_stb)
    );

    function automatic int model_div();
        if (mode == 2'd0) return 12;
        return dbl_rate ? 16 : 32;
    endfunction

    function automatic int model_tick(bit is_rx);
        if (mode == 2'd0 || mode == 2'd2) return int'(mach_tick);
        if (is_rx) return rx_clk_t2 ? int'(t2_rx_ovf) : int'(t1_ovf);
        return tx_clk_t2 ? int'(t2_tx_ovf) : int'(t1_ovf);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model updated at each edge, then compared a quarter period later
    always @(posedge clk) begin
        if (rst) begin
            m_tx_acc = 0; m_rx_acc = 0; m_tx_stb = 0; m_rx_stb = 0;
        end else begin
            if (!tx_active) begin
                m_tx_acc = 0; m_tx_stb = 0;
            end else begin
                m_tx_acc += model_tick(0);
                m_tx_stb = (m_tx_acc >= model_div());
                if (m_tx_stb) m_tx_acc -= model_div();
            end
            if (!rx_active) begin
                m_rx_acc = 0; m_rx_stb = 0;
            end else begin
                m_rx_acc += model_tick(1);
                m_rx_stb = (m_rx_acc >= model_div());
                if (m_rx_stb) m_rx_acc -= model_div();
            end
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            check({phase, " R9 model tx"}, int'(tx_bit_stb), int'(m_tx_stb));
            check({phase, " R9 model rx"}, int'(rx_bit_stb), int'(m_rx_stb));
            tx_cnt += int'(tx_bit_stb === 1'b1);
            rx_cnt += int'(rx_bit_stb === 1'b1);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        tx_active = 0; rx_active = 0;
        cycles(1);
        tx_active = 1; rx_active = 1;
        tx_cnt = 0; rx_cnt = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cycles(3);
        check("R1 tx reset", int'(tx_bit_stb), 0);
        check("R1 rx reset", int'(rx_bit_stb), 0);
        rst = 0;
        tx_active = 1; rx_active = 1;
        cycles(1);
        check("R1 tx first clock", int'(tx_bit_stb), 0);

        // R2: shift mode, timer pulses and double-rate ignored
        phase = "R2";
        mode = 2'd0; dbl_rate = 1; mach_tick = 1; t1_ovf = 1; t2_tx_ovf = 1; t2_rx_ovf = 1;
        restart();
        cycles(120);
        check("R2 tx /12", tx_cnt, 10);
        check("R2 rx /12", rx_cnt, 10);

        // R3: fixed-rate mode
        phase = "R3";
        mode = 2'd2; dbl_rate = 1;
        restart();
        cycles(160);
        check("R3 tx /16", tx_cnt, 10);
        dbl_rate = 0;
        restart();
        cycles(320);
        check("R3 rx /32", rx_cnt, 10);

        // R4 R5 R6: timer sources, tx on t1 every clock, rx on t2 every other clock
        phase = "R5";
        mode = 2'd1; dbl_rate = 1; tx_clk_t2 = 0; rx_clk_t2 = 1; t2_tx_ovf = 0;
        restart();
        for (int i = 0; i < 64; i++) begin
            t1_ovf = 1; t2_rx_ovf = (i % 2 == 0); mach_tick = 1;
            cycles(1);
        end
        check("R4 R5 tx t1 /16", tx_cnt, 4);
        check("R6 rx t2 /16", rx_cnt, 2);
        phase = "R6";
        mode = 2'd3; dbl_rate = 0; tx_clk_t2 = 1; rx_clk_t2 = 0; t2_rx_ovf = 1;
        restart();
        for (int i = 0; i < 64; i++) begin
            t2_tx_ovf = 1; t1_ovf = (i % 2 == 0);
            cycles(1);
        end
        check("R5 tx t2 /32", tx_cnt, 2);
        check("R6 rx t1 /32", rx_cnt, 1);

        // R7: inactive direction stays quiet, other continues
        phase = "R7";
        mode = 2'd0; mach_tick = 1; t1_ovf = 0; t2_tx_ovf = 0; t2_rx_ovf = 0;
        restart();
        tx_active = 0;
        cycles(60);
        check("R7 tx idle", tx_cnt, 0);
        check("R7 rx running", rx_cnt, 5);
        tx_active = 1;
        cycles(5);
        tx_active = 0;
        cycles(1);
        tx_active = 1; tx_cnt = 0;
        cycles(11);
        check("R7 tx realigned early", tx_cnt, 0);
        cycles(1);
        check("R7 tx realigned strobe", tx_cnt, 1);

        // R8: remainder kept across a divisor shrink
        phase = "R8";
        mode = 2'd2; dbl_rate = 0; mach_tick = 1;
        restart();
        cycles(20);
        check("R8 no strobe at 20/32", tx_cnt, 0);
        mach_tick = 0; dbl_rate = 1;
        cycles(1);
        check("R8 strobe without tick", tx_cnt, 1);
        mach_tick = 1; tx_cnt = 0;
        cycles(11);
        check("R8 remainder 4 then 11", tx_cnt, 0);
        cycles(1);
        check("R8 remainder strobe", tx_cnt, 1);

        // R9: random stretch compared against the model every clock
        phase = "R9";
        for (int i = 0; i < 4000; i++) begin
            if (i % 97 == 0) begin
                mode = 2'($urandom_range(0, 3));
                dbl_rate = 1'($urandom_range(0, 1));
                tx_clk_t2 = 1'($urandom_range(0, 1));
                rx_clk_t2 = 1'($urandom_range(0, 1));
            end
            mach_tick = ($urandom_range(0, 3) != 0);
            t1_ovf = ($urandom_range(0, 2) == 0);
            t2_tx_ovf = ($urandom_range(0, 1) == 0);
            t2_rx_ovf = ($urandom_range(0, 4) == 0);
            tx_active = ($urandom_range(0, 49) != 0);
            rx_active = ($urandom_range(0, 39) != 0);
            cycles(1);
        end

        cycles(1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule